// File: doc/BRIEF.md
# Host Command Port for a Cell Switch Controller

This block is the host-facing command port of a cell switch controller. A host processor talks to it over an 8-bit bus, here split into an input byte, an output byte and an output enable. A select line, a read/write line and a strobe steer each access. With the select low the host reaches the command/status register, and with the select high it reaches the data registers. Writes are captured on the rising edge of the strobe. Reads are combinational: the bus is driven while the strobe is low with read/write high.

Every captured write crosses into the system clock domain through a toggle handshake and a two-flop synchronizer. It is then handled by a small command controller. A known command code is offered to an executor on a valid/ready pair. `exec_valid` stays high and `exec_code` stays fixed until `exec_ready` is seen, so the executor may take any number of cycles. The cycle of acceptance sets the acknowledge bit that the host polls. Only after acknowledge does the host send the fixed number of argument bytes that the command declares. Those bytes reach the executor as single-cycle `arg_valid` pulses with no back-pressure, so the executor must take each byte in the cycle it appears. The read-status command latches a result word at acceptance, and the host then reads that word back byte by byte.

The host must leave at least four system clocks between rising strobe edges.

Top module: `mgr_cmd_if`

## Requirements
- R1: After reset, the status register reads 0x00 and the output enable is low.
- R2: `m_doe` is high exactly while `mstrb` is low and `m_rw` is high; at all other times the bus is released.
- R3: A read with `m_dsel` low returns the status byte. Its bit 7 is acknowledge, bit 6 is invalid-command, bit 5 is the surplus-write error, and bits 4..0 read as 0. A read with `m_dsel` high returns the current result byte.
- R4: A command write (`m_rw` low, `m_dsel` low) with a known code clears bit 7 and raises `exec_valid` with that code. `exec_valid` and `exec_code` stay unchanged until the cycle with `exec_ready` high. From the next cycle, bit 7 reads 1.
- R5: The known codes are 0x03, 0x07, 0x08, 0x09, 0x0A, 0x0B, 0x0C, 0x0D and 0x0E. Any other code does not raise `exec_valid`; it sets bits 7 and 6. Bit 6 is cleared by the next known command.
- R6: After acknowledge, each data write up to the command's byte count produces exactly one `arg_valid` pulse carrying `arg_byte`, with `arg_idx` counting from 0. The counts are: 0x03→4, 0x07→0, 0x08→2, 0x09→6, 0x0A→1, 0x0B→1, 0x0C→0, 0x0D→3, 0x0E→3. Address arguments occupy indices 0 and 1.
- R7: Writes spaced at the minimum of four system clocks are each forwarded exactly once and in order.
- R8: A data write that exceeds the count, arrives before acknowledge, or follows an invalid code is not forwarded. It sets bit 5, which stays set until reset.
- R9: At acceptance of code 0x07, `exec_result` is latched. Successive data reads then return its bytes, least significant first, followed by 0x00. Every command write restarts the read sequence at byte 0.
- R10: A data write handled in the same system clock as the executor's acceptance is treated as arriving before acknowledge (R8), while acknowledge is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| mstrb | input | 1 | Host strobe; writes captured on its rising edge |
| m_dsel | input | 1 | 1 = data registers, 0 = command/status |
| m_rw | input | 1 | 1 = read, 0 = write |
| m_din | input | 8 | Byte from host |
| m_dout | output | 8 | Byte to host |
| m_doe | output | 1 | Drive enable for `m_dout` |
| exec_valid | output | 1 | Command offered to executor |
| exec_code | output | 8 | Offered command code |
| exec_ready | input | 1 | Executor accepts command |
| exec_result | input | 32 | Result word for the read-status command |
| arg_valid | output | 1 | Argument byte strobe (one cycle) |
| arg_byte | output | 8 | Argument byte |
| arg_idx | output | 4 | Index of the argument byte |

## Verification
The collision checked here is between the executor's acceptance and the handling of a synchronized data write in the same system clock. The bench places a data strobe edge on a falling clock edge, so the synchronized write is handled exactly three rising edges later. It raises `exec_ready` for that one rising edge only. It then expects no argument pulse, the surplus bit set and acknowledge set, and it confirms that the next data byte is forwarded with index 0.

// File: rtl/mgr_cmd_pkg.sv
package mgr_cmd_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;
  localparam logic [BYTE_W-1:0] OP_RDSTAT = 8'h07;

  function automatic logic code_known(input logic [BYTE_W-1:0] c);
    case (c)
      8'h03, 8'h07, 8'h08, 8'h09, 8'h0A,
      8'h0B, 8'h0C, 8'h0D, 8'h0E: code_known = 1'b1;
      default:                   code_known = 1'b0;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] arg_count(input logic [BYTE_W-1:0] c);
    case (c)
      8'h03:        arg_count = 4'd4;
      8'h08:        arg_count = 4'd2;
      8'h09:        arg_count = 4'd6;
      8'h0A, 8'h0B: arg_count = 4'd1;
      8'h0D, 8'h0E: arg_count = 4'd3;
      default:      arg_count = 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/hb_strobe_side.sv
module hb_strobe_side #(
  parameter int DW        = 8,
  parameter int RES_BYTES = 4,
  localparam int IDXW     = $clog2(RES_BYTES + 1)
) (
  input  logic            mstrb,
  input  logic            rst,
  input  logic            m_rw,
  input  logic            m_dsel,
  input  logic [DW-1:0]   m_din,
  output logic            hold_sel,
  output logic [DW-1:0]   hold_byte,
  output logic            wtog,
  output logic [IDXW-1:0] rd_idx
);
  localparam logic [IDXW-1:0] IDX_END = IDXW'(RES_BYTES);

  always_ff @(posedge mstrb or posedge rst) begin
    if (rst) begin
      hold_sel  <= 1'b0;
      hold_byte <= '0;
      wtog      <= 1'b0;
      rd_idx    <= '0;
    end else if (!m_rw) begin
      hold_sel  <= m_dsel;
      hold_byte <= m_din;
      wtog      <= ~wtog;
      if (!m_dsel) rd_idx <= '0;
    end else if (m_dsel && rd_idx != IDX_END) begin
      rd_idx <= rd_idx + 1'b1;
    end
  end

  always_comb begin
    AST_IDX_RANGE: assert (rst || rd_idx <= IDX_END); // R9
  end
endmodule

// File: rtl/hb_sync.sv
module hb_sync (
  input  logic clk,
  input  logic rst,
  input  logic tog_in,
  output logic evt
);
  logic s1, s2, s3;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= tog_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign evt = s2 ^ s3;
endmodule

// File: rtl/hb_cmd_ctrl.sv
module hb_cmd_ctrl
  import mgr_cmd_pkg::*;
#(
  parameter int RES_BYTES = 4,
  localparam int RW       = RES_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt,
  input  logic              ev_sel,
  input  logic [BYTE_W-1:0] ev_byte,
  output logic              exec_valid,
  output logic [BYTE_W-1:0] exec_code,
  input  logic              exec_ready,
  input  logic [RW-1:0]     exec_result,
  output logic              arg_valid,
  output logic [BYTE_W-1:0] arg_byte,
  output logic [CNT_W-1:0]  arg_idx,
  output logic              ack,
  output logic              bad,
  output logic              ovr,
  output logic [RW-1:0]     result
);
  logic [CNT_W-1:0] remain, cnt;
  logic hs;

  assign hs = exec_valid & exec_ready;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      exec_valid <= 1'b0;
      exec_code  <= '0;
      arg_valid  <= 1'b0;
      arg_byte   <= '0;
      arg_idx    <= '0;
      ack        <= 1'b0;
      bad        <= 1'b0;
      ovr        <= 1'b0;
      result     <= '0;
      remain     <= '0;
      cnt        <= '0;
    end else begin
      arg_valid <= 1'b0;
      if (hs) begin
        exec_valid <= 1'b0;
        ack        <= 1'b1;
        if (exec_code == OP_RDSTAT) result <= exec_result;
      end
      if (evt) begin
        if (!ev_sel) begin
          cnt <= '0;
          if (code_known(ev_byte)) begin
            exec_code  <= ev_byte;
            exec_valid <= 1'b1;
            ack        <= 1'b0;
            bad        <= 1'b0;
            remain     <= arg_count(ev_byte);
          end else begin
            exec_valid <= 1'b0;
            ack        <= 1'b1;
            bad        <= 1'b1;
            remain     <= '0;
          end
        end else if (ack && remain != '0) begin
          arg_valid <= 1'b1;
          arg_byte  <= ev_byte;
          arg_idx   <= cnt;
          cnt       <= cnt + 1'b1;
          remain    <= remain - 1'b1;
        end else begin
          ovr <= 1'b1;
        end
      end
    end
  end

  AST_EXEC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (exec_valid && !exec_ready && !evt) |=> (exec_valid && $stable(exec_code))); // R4
  AST_ACK_ON_HS: assert property (@(posedge clk) disable iff (rst)
    (hs && !(evt && !ev_sel)) |=> ack); // R4
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovr |=> ovr); // R8
  AST_ARG_ACKED: assert property (@(posedge clk) disable iff (rst)
    arg_valid |-> ack); // R6
  AST_BAD_NOEXEC: assert property (@(posedge clk) disable iff (rst)
    bad |-> !exec_valid); // R5
endmodule

// File: rtl/mgr_cmd_if.sv
module mgr_cmd_if
  import mgr_cmd_pkg::*;
#(
  parameter int RES_BYTES = 4,
  localparam int RW       = RES_BYTES * BYTE_W,
  localparam int IDXW     = $clog2(RES_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mstrb,
  input  logic              m_dsel,
  input  logic              m_rw,
  input  logic [BYTE_W-1:0] m_din,
  output logic [BYTE_W-1:0] m_dout,
  output logic              m_doe,
  output logic              exec_valid,
  output logic [BYTE_W-1:0] exec_code,
  input  logic              exec_ready,
  input  logic [RW-1:0]     exec_result,
  output logic              arg_valid,
  output logic [BYTE_W-1:0] arg_byte,
  output logic [CNT_W-1:0]  arg_idx
);
  logic              hold_sel, wtog, evt, ack, bad, ovr;
  logic [BYTE_W-1:0] hold_byte;
  logic [IDXW-1:0]   rd_idx;
  logic [RW-1:0]     result;
  logic [BYTE_W-1:0] res_bytes [2**IDXW];
  logic [BYTE_W-1:0] status;

  hb_strobe_side #(.DW(BYTE_W), .RES_BYTES(RES_BYTES)) u_strb (
    .mstrb(mstrb), .rst(rst), .m_rw(m_rw), .m_dsel(m_dsel), .m_din(m_din),
    .hold_sel(hold_sel), .hold_byte(hold_byte), .wtog(wtog), .rd_idx(rd_idx)
  );

  hb_sync u_sync (.clk(clk), .rst(rst), .tog_in(wtog), .evt(evt));

  hb_cmd_ctrl #(.RES_BYTES(RES_BYTES)) u_ctrl (
    .clk(clk), .rst(rst), .evt(evt), .ev_sel(hold_sel), .ev_byte(hold_byte),
    .exec_valid(exec_valid), .exec_code(exec_code), .exec_ready(exec_ready),
    .exec_result(exec_result), .arg_valid(arg_valid), .arg_byte(arg_byte),
    .arg_idx(arg_idx), .ack(ack), .bad(bad), .ovr(ovr), .result(result)
  );

  for (genvar i = 0; i < 2**IDXW; i++) begin : g_res
    if (i < RES_BYTES) begin : g_live
      assign res_bytes[i] = result[i*BYTE_W +: BYTE_W];
    end else begin : g_zero
      assign res_bytes[i] = '0;
    end
  end

  assign status = {ack, bad, ovr, 5'b0};
  assign m_doe  = ~mstrb & m_rw;
  assign m_dout = m_dsel ? res_bytes[rd_idx] : status;
endmodule

// File: tb/mgr_cmd_if_tb_top.sv
module mgr_cmd_if_tb_top;
  logic clk = 0, rst = 1, mstrb = 1, m_dsel = 0, m_rw = 1;
  logic [7:0] m_din = 0, m_dout, exec_code, arg_byte;
  logic m_doe, exec_valid, exec_ready = 0, arg_valid;
  logic [31:0] exec_result = 0;
  logic [3:0] arg_idx;
  int n_run = 0, n_fail = 0;
  logic [11:0] arg_q [$];
  logic [7:0]  exe_q [$];

  always #5 clk = ~clk;

  mgr_cmd_if dut_i (.clk(clk), .rst(rst), .mstrb(mstrb), .m_dsel(m_dsel),
    .m_rw(m_rw), .m_din(m_din), .m_dout(m_dout), .m_doe(m_doe),
    .exec_valid(exec_valid), .exec_code(exec_code), .exec_ready(exec_ready),
    .exec_result(exec_result), .arg_valid(arg_valid), .arg_byte(arg_byte),
    .arg_idx(arg_idx));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: argument bytes
  always @(negedge clk) if (!rst && arg_valid) begin
    n_run++;
    if (arg_q.size() == 0) begin
      n_fail++;
      $display("FAIL R8 actual=%h expected=none", {arg_idx, arg_byte});
    end else begin
      logic [11:0] e;
      e = arg_q.pop_front();
      if ({arg_idx, arg_byte} !== e) begin
        n_fail++;
        $display("FAIL R6 actual=%h expected=%h", {arg_idx, arg_byte}, e);
      end
    end
  end

  // monitor: executor handshakes
  always @(posedge clk) if (!rst && exec_valid && exec_ready) begin
    n_run++;
    if (exe_q.size() == 0) begin
      n_fail++;
      $display("FAIL R5 actual=%h expected=none", exec_code);
    end else begin
      logic [7:0] e;
      e = exe_q.pop_front();
      if (exec_code !== e) begin
        n_fail++;
        $display("FAIL R4 actual=%h expected=%h", exec_code, e);
      end
    end
  end

  task automatic hwrite(input logic sel, input logic [7:0] b);
    @(negedge clk); m_rw = 0; m_dsel = sel; m_din = b; mstrb = 0;
    @(negedge clk); mstrb = 1;
    repeat (4) @(negedge clk);
    m_rw = 1;
  endtask

  task automatic hread(input logic sel, output logic [7:0] b, output logic oe);
    @(negedge clk); m_rw = 1; m_dsel = sel; mstrb = 0;
    @(negedge clk); b = m_dout; oe = m_doe; mstrb = 1;
    @(negedge clk);
  endtask

  task automatic accept();
    @(negedge clk); exec_ready = 1;
    @(negedge clk); exec_ready = 0;
    @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] c);
    if (c inside {8'h03, 8'h07, 8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'h0E})
      exe_q.push_back(c);
    hwrite(0, c);
  endtask

  task automatic arg(input logic [3:0] i, input logic [7:0] b);
    arg_q.push_back({i, b});
    hwrite(1, b);
  endtask

  initial begin
    #2_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] b; logic oe;
    repeat (3) @(negedge clk); rst = 0;
    // R1 reset state, R2 bus drive
    check("R2 idle oe", {31'b0, m_doe}, 0);
    hread(0, b, oe);
    check("R1 status", b, 8'h00);
    check("R2 read oe", {31'b0, oe}, 1);
    check("R2 released", {31'b0, m_doe}, 0);
    // R4 pending then ack
    cmd(8'h09);
    hread(0, b, oe);
    check("R4 ack low", b, 8'h00);
    repeat (5) @(negedge clk);
    check("R4 held valid", {31'b0, exec_valid}, 1);
    check("R4 code", exec_code, 8'h09);
    accept();
    check("R4 valid drop", {31'b0, exec_valid}, 0);
    hread(0, b, oe);
    check("R4 ack high", b, 8'h80);
    // R6 R7 six args back to back
    for (int i = 0; i < 6; i++) arg(4'(i), 8'hA0 + 8'(i));
    check("R7 all forwarded", arg_q.size(), 0);
    // R8 surplus
    hwrite(1, 8'h55);
    hread(0, b, oe);
    check("R8 surplus", b, 8'hA0);
    // R5 unknown code
    hwrite(0, 8'h05);
    check("R5 no exec", {31'b0, exec_valid}, 0);
    hread(0, b, oe);
    check("R5 bad flag", b, 8'hE0);
    // R9 read-status result
    exec_result = 32'h44332211;
    cmd(8'h07);
    accept();
    exec_result = 32'hDEADBEEF;
    hread(0, b, oe);
    check("R5 bad cleared", b, 8'hA0);
    hread(1, b, oe); check("R9 byte0", b, 8'h11);
    check("R3 data oe", {31'b0, oe}, 1);
    hread(1, b, oe); check("R9 byte1", b, 8'h22);
    hread(1, b, oe); check("R9 byte2", b, 8'h33);
    hread(1, b, oe); check("R9 byte3", b, 8'h44);
    hread(1, b, oe); check("R9 past end", b, 8'h00);
    cmd(8'h0C);
    accept();
    hread(1, b, oe); check("R9 restart", b, 8'h11);
    cmd(8'h0E);
    accept();
    arg(0, 8'h01); arg(1, 8'h02); arg(2, 8'h03);
    check("R6 param args", arg_q.size(), 0);
    // R10 collision after fresh reset
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    hread(0, b, oe); check("R1 after reset", b, 8'h00);
    cmd(8'h0B);
    @(negedge clk); m_rw = 0; m_dsel = 1; m_din = 8'h77; mstrb = 0;
    @(negedge clk); mstrb = 1;
    @(negedge clk);
    @(negedge clk); exec_ready = 1;
    @(negedge clk); exec_ready = 0; m_rw = 1;
    repeat (3) @(negedge clk);
    hread(0, b, oe);
    check("R10 collision", b, 8'hA0);
    arg(0, 8'h66);
    check("R10 next forwarded", arg_q.size(), 0);
    check("R4 exec queue empty", exe_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule